// File: doc/BRIEF.md
# Six-Channel Digital Volume Attenuator

This block scales six 24-bit two's-complement audio channels by a per-channel attenuation set in 1 dB steps from 0 to 119 dB. Each channel has an 8-bit control word. The top bit mutes the channel and the low seven bits give the attenuation in dB. One sample frame enters with each pulse on `smp_stb`, and the scaled frame leaves one clock later with `out_stb`.

A shared 2-bit mode chooses how a changed control word reaches the applied attenuation:
- at once;
- at a zero crossing of that channel's signal, with a timeout;
- by a gradual ramp of 1 dB per step;
- by a ramp whose steps wait for zero crossings.

A gang input lets channel 0's word drive all six channels. The dB-to-linear gain comes from a six-entry fractional table and a right shift.

Top module: `vol_atten6`

## Requirements
- R1: Each channel's output equals floor(x * G / 65536), where x is the input sample and G = B[a mod 6] >> (a div 6) for applied attenuation a. B = {65536, 58409, 52057, 46396, 41350, 36854}. The result saturates to the signed 24-bit range. Channel c uses bits [24c+23:24c] of the sample buses and bits [8c+7:8c] of `ctl_word`.
- R2: When bit 7 of a channel's effective control word is 1, the channel's target is mute, and a muted channel outputs 0.
- R3: Attenuation codes 120 to 127 in bits 6:0 are treated as mute and give an output of 0.
- R4: In mode 1, a changed target is applied at the first sample strobe where the current input and the previous input of that channel differ in sign, or either of them is zero. On strobes without such a crossing, the applied attenuation is held.
- R5: In mode 1, if no crossing occurs, the change is applied on the 512th consecutive strobe during which it is pending.
- R6: In mode 2, the applied attenuation moves 1 dB toward the target on every 8th strobe while it differs from the target. Mute counts as level 120 on this scale.
- R7: In mode 3, a 1 dB step becomes due after 8 pending strobes. The step is then taken on the first strobe that is a crossing in the sense of R4, or after 512 pending strobes if none occurs.
- R8: In mode 0, a new setting is applied at the first strobe that sees it. A setting always affects outputs from the frame after the strobe that applies it.
- R9: `out_stb` is high exactly one cycle after each `smp_stb` cycle, and `smp_out` is updated on that same cycle.
- R10: When `gang` is 1, channel 0's control word (bits 7:0) sets the target of all six channels.
- R11: After reset, `smp_out` and `out_stb` are 0, every channel's applied attenuation is 0 dB, and every previous sample is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Input frame valid, one cycle per frame |
| smp_in | input | 144 | Six packed 24-bit signed samples |
| ctl_word | input | 48 | Six packed control words {mute, atten[6:0]} |
| upd_mode | input | 2 | 0 immediate, 1 zero cross, 2 ramp, 3 ramp on zero cross |
| gang | input | 1 | Channel 0 word controls all channels |
| smp_out | output | 144 | Six packed 24-bit attenuated samples |
| out_stb | output | 1 | Output frame valid |

## Verification
A wrong applied attenuation shows as a wrong scaled sample on the very next output frame, so any fault in the gain path or the update decision appears within one frame of the strobe that caused it.

A fault in the per-channel timer shows later. In ramp mode it moves the 1 dB steps away from every 8th frame. In zero-cross mode it applies the change too early or too late around the 512th pending frame.

A wrong previous-sample register shows as a change that lands on the wrong frame around a sign flip. The bench therefore checks every frame of each update sequence, not only the final level.

// File: rtl/vol_atten6.sv
module vol_atten6 #(
  parameter int NCH          = 6,
  parameter int DW           = 24,
  parameter int ZC_LIMIT     = 512,
  parameter int RAMP_PERIODS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic [NCH*DW-1:0] smp_in,
  input  logic [NCH*8-1:0]  ctl_word,
  input  logic [1:0]        upd_mode,
  input  logic              gang,
  output logic [NCH*DW-1:0] smp_out,
  output logic              out_stb
);
  localparam int GF = 16;
  localparam int GW = GF + 1;
  localparam int PW = DW + GW + 1;
  localparam int TW = $clog2(ZC_LIMIT);
  localparam logic [6:0] MUTE_LVL = 7'd120;
  localparam logic signed [PW-1:0] YMAX = PW'((64'sd1 <<< (DW-1)) - 64'sd1);
  localparam logic signed [PW-1:0] YMIN = -YMAX - PW'(1);

  function automatic logic [GW-1:0] gain_of(input logic [6:0] a);
    logic [4:0] q;
    logic [2:0] r;
    logic [GW-1:0] b;
    q = 5'(a / 7'd6);
    r = 3'(a % 7'd6);
    case (r)
      3'd0: b = 17'd65536;
      3'd1: b = 17'd58409;
      3'd2: b = 17'd52057;
      3'd3: b = 17'd46396;
      3'd4: b = 17'd41350;
      default: b = 17'd36854;
    endcase
    return b >> q;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) out_stb <= 1'b0;
    else        out_stb <= smp_stb;
  end

  p_stb_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> out_stb);
  p_stb_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> !out_stb);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [DW-1:0] x, prv, y_sat;
    logic [7:0]           w;
    logic [6:0]           tgt, att, step_val;
    logic [TW-1:0]        tmr;
    logic [GW-1:0]        g;
    logic signed [PW-1:0] prod, y;
    logic                 xing, tmo, due, jump, stp;

    assign x        = smp_in[c*DW +: DW];
    assign w        = gang ? ctl_word[7:0] : ctl_word[c*8 +: 8];
    assign tgt      = (w[7] || w[6:0] > 7'd119) ? MUTE_LVL : w[6:0];
    assign xing     = (x[DW-1] != prv[DW-1]) || (x == '0) || (prv == '0);
    assign tmo      = tmr == TW'(ZC_LIMIT - 1);
    assign due      = tmr >= TW'(RAMP_PERIODS - 1);
    assign step_val = (tgt > att) ? att + 7'd1 : att - 7'd1;
    assign g        = (att == MUTE_LVL) ? '0 : gain_of(att);
    assign prod     = x * $signed({1'b0, g});
    assign y        = prod >>> GF;
    assign y_sat    = (y > YMAX) ? YMAX[DW-1:0] : (y < YMIN) ? YMIN[DW-1:0] : y[DW-1:0];

    always_comb begin
      jump = 1'b0;
      stp  = 1'b0;
      case (upd_mode)
        2'd0: jump = 1'b1;
        2'd1: jump = xing || tmo;
        2'd2: stp  = due;
        default: stp = due && (xing || tmo);
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        att <= '0;
        tmr <= '0;
        prv <= '0;
        smp_out[c*DW +: DW] <= '0;
      end else if (smp_stb) begin
        prv <= x;
        smp_out[c*DW +: DW] <= y_sat;
        if (att != tgt) begin
          if (jump) begin
            att <= tgt;
            tmr <= '0;
          end else if (stp) begin
            att <= step_val;
            tmr <= '0;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end else begin
          tmr <= '0;
        end
      end
    end

    // R2 and R3 both end in the mute level
    p_mute_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && att == MUTE_LVL) |=> (smp_out[c*DW +: DW] == '0));
    p_hold_no_cross_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && upd_mode == 2'd1 && !xing && !tmo) |=> $stable(att));
    p_ramp_unit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && upd_mode == 2'd2) |=>
        (att == $past(att) || att == $past(att) + 7'd1 || att == $past(att) - 7'd1));
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb |=> $stable(att));
  end
endmodule

// File: tb/test_vol_atten6.sv
`timescale 1ns/1ps
module test_vol_atten6;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         smp_stb = 1'b0;
  logic [143:0] smp_in = '0;
  logic [47:0]  ctl_word = '0;
  logic [1:0]   upd_mode = 2'd0;
  logic         gang = 1'b0;
  logic [143:0] smp_out;
  logic         out_stb;

  int checks = 0;
  int errors = 0;
  logic signed [23:0] xs [6];
  int ea [6];

  vol_atten6 i_vol_atten6 (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_in(smp_in),
    .ctl_word(ctl_word), .upd_mode(upd_mode), .gang(gang),
    .smp_out(smp_out), .out_stb(out_stb)
  );

  always #2 clk = ~clk;

  function automatic logic signed [23:0] model(logic signed [23:0] x, int a);
    longint b [6] = '{65536, 58409, 52057, 46396, 41350, 36854};
    longint g, p;
    if (a >= 120) return '0;
    g = b[a % 6] >> (a / 6);
    p = longint'(x) * g;
    p = p >>> 16;
    if (p > 8388607) p = 8388607;
    if (p < -8388608) p = -8388608;
    return p[23:0];
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_frame(string req);
    @(negedge clk);
    for (int c = 0; c < 6; c++) smp_in[c*24 +: 24] = xs[c];
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    chk("R9", out_stb, 1);
    for (int c = 0; c < 6; c++)
      chk(req, $signed(smp_out[c*24 +: 24]), model(xs[c], ea[c]));
  endtask

  task automatic set_all(logic [7:0] w);
    for (int c = 0; c < 6; c++) ctl_word[c*8 +: 8] = w;
  endtask

  task automatic fill(int base, bit neg);
    for (int c = 0; c < 6; c++) xs[c] = neg ? 24'(-(base + c*1111)) : 24'(base + c*1111);
  endtask

  task automatic set_ea(int a);
    for (int c = 0; c < 6; c++) ea[c] = a;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R11", smp_out, 0);
    chk("R11", out_stb, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", out_stb, 0);

    // R11: unity gain out of reset; R1 sample extremes
    set_ea(0);
    fill(123457, 0);
    xs[0] = -24'sd8388608; xs[1] = 24'sd8388607;
    do_frame("R11");

    // R1, R3, R8: immediate mode sweep over all codes
    upd_mode = 2'd0;
    for (int k = 0; k < 128; k++) begin
      for (int c = 0; c < 6; c++) begin
        int code = (k + 23*c) % 128;
        ctl_word[c*8 +: 8] = 8'(code);
        if (k % 5 == 0)      xs[c] = -24'sd8388608;
        else if (k % 5 == 1) xs[c] = 24'sd8388607;
        else                 xs[c] = 24'((k*104729 + c*7919) % 16777216 - 8388608);
      end
      do_frame("R8");
      for (int c = 0; c < 6; c++) begin
        int code = (k + 23*c) % 128;
        ea[c] = (code > 119) ? 120 : code;
      end
      do_frame(k % 2 ? "R3" : "R1");
    end

    // R2: mute flag
    set_all(8'h85);
    fill(500000, 1);
    do_frame("R2");
    set_ea(120);
    do_frame("R2");

    // R10: gang on channel 0
    gang = 1'b1;
    ctl_word = {8'd40, 8'd50, 8'd60, 8'd70, 8'd80, 8'd12};
    do_frame("R10");
    set_ea(12);
    do_frame("R10");
    ctl_word[7:0] = 8'h80;
    do_frame("R10");
    set_ea(120);
    do_frame("R10");
    gang = 1'b0;
    set_all(8'd0);
    do_frame("R8");
    set_ea(0);
    do_frame("R8");

    // R4: zero-cross gating
    upd_mode = 2'd1;
    fill(300000, 0);
    do_frame("R4");
    set_all(8'd20);
    for (int n = 0; n < 5; n++) do_frame("R4");
    fill(300000, 1);
    do_frame("R4");
    set_ea(20);
    do_frame("R4");

    // R5: timeout after 512 pending strobes
    set_all(8'd33);
    for (int n = 1; n <= 512; n++) do_frame("R5");
    set_ea(33);
    do_frame("R5");

    // R6: soft ramp
    upd_mode = 2'd0;
    set_all(8'd0);
    fill(700000, 0);
    do_frame("R8");
    set_ea(0);
    do_frame("R8");
    upd_mode = 2'd2;
    set_all(8'd3);
    for (int n = 1; n <= 40; n++) begin
      set_ea((n - 1) / 8 > 3 ? 3 : (n - 1) / 8);
      do_frame("R6");
    end

    // R7: ramp steps wait for a crossing once due
    upd_mode = 2'd3;
    set_all(8'd4);
    set_ea(3);
    for (int n = 1; n <= 10; n++) begin
      fill(900000, (n >= 4 && n <= 9));
      do_frame("R7");
    end
    set_ea(4);
    do_frame("R7");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule